// File: doc/BRIEF.md
# Narrow-Width Flag Generating ALU

This block is an arithmetic and logic unit for a core whose registers are 24 bits wide while its condition codes describe a 16-bit quantity. It takes two 24-bit operands and an operation code. It produces a 24-bit result in the same cycle. It derives carry, overflow, zero and negative from the low 16 bits of the computed value only. Those four flags are captured in an 8-bit status register on the clock edge when flag update is enabled.

The upper four bits of the same status register hold an interrupt level and an interrupt enable. The block stores them and presents them, and nothing else. They are written through a separate load strobe, and no operation touches them. Add with carry and subtract with borrow take their carry-in or borrow-in from the stored carry flag. Compare sets the flags as subtract does, but passes operand A to the result unchanged, so no result is written.

Top module: `nfa_alu`

## Requirements
- R1: Status byte layout: bits 7..5 interrupt level, bit 4 interrupt enable, bit 3 carry (C), bit 2 overflow (V), bit 1 zero (Z), bit 0 negative (N). Synchronous reset clears the whole byte to 0x00.
- R2: Opcodes are ADD=0, ADC=1, SUB=2, SBC=3, CMP=4, AND=5, OR=6, XOR=7, NOT=8, SLL=9, SRL=10. ADD gives the full 24-bit sum modulo 2^24. ADC also adds the stored C at bit 0.
- R3: For ADD and ADC, C is set when the 16-bit unsigned sum of the operands' low halves plus the carry-in exceeds 0xffff; otherwise C is cleared.
- R4: SUB gives A-B modulo 2^24 and SBC gives A-B-C. For both, C is set when the 16-bit unsigned difference goes below zero; otherwise C is cleared.
- R5: For ADD and ADC, V is set when both operands have the same bit 15 and the result's bit 15 differs from it.
- R6: For SUB, SBC and CMP, V is set when the operands' bit 15 differ and the result's bit 15 differs from A's.
- R7: AND, OR, XOR and NOT(A) give the bitwise 24-bit result. They clear V and leave C unchanged.
- R8: SLL and SRL shift A logically by B[4:0] places, and shifts of 24 or more give zero. Shifts clear V and leave C unchanged.
- R9: Z is set exactly when bits 15..0 of the computed value are all zero, whatever bits 23..16 hold.
- R10: N equals bit 15 of the computed value.
- R11: CMP updates C, V, Z and N as SUB does, and the result output equals A.
- R12: With flag update low, C, V, Z and N keep their values; the result output still follows the operation.
- R13: The level and enable bits load from the mode input only on a load strobe, and are otherwise unchanged by any operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code (R2 encoding) |
| a_i | input | 24 | Operand A |
| b_i | input | 24 | Operand B or shift amount |
| flg_en_i | input | 1 | Capture C, V, Z, N at the clock edge |
| mode_we_i | input | 1 | Load strobe for level and enable bits |
| mode_d_i | input | 4 | New {level[2:0], enable} |
| res_o | output | 24 | Combinational result |
| stat_o | output | 8 | Registered status byte |

## Verification
The bench builds the block with its defaults: a 24-bit datapath, a 16-bit flag view and a 3-bit level. That gap of eight bits lets vectors reach results whose low half is zero while the upper byte is not, and results whose 24-bit carry differs from the 16-bit one. The stored carry is preset before every table vector, so the ADC and SBC entries run with both carry-in values. Directed cases cover a set V being cleared by a logical op and by a shift, the hold when flag update is low, and the mode bits surviving arithmetic.

// File: rtl/nfa_pkg.sv
package nfa_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBC = 4'd3,
    OP_CMP = 4'd4,
    OP_AND = 4'd5,
    OP_OR  = 4'd6,
    OP_XOR = 4'd7,
    OP_NOT = 4'd8,
    OP_SLL = 4'd9,
    OP_SRL = 4'd10
  } nfa_op_e;

  typedef struct packed {
    logic c;
    logic v;
    logic z;
    logic n;
  } nfa_flags_t;
endpackage

// File: rtl/nfa_arith.sv
module nfa_arith #(
  parameter int DW = 24,
  parameter int FW = 16
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          sub,
  input  logic          cin,
  output logic [DW-1:0] sum,
  output logic          c_nar,
  output logic          v_nar
);
  logic [DW-1:0] bx;
  logic          cx;
  logic [FW:0]   low;

  always_comb begin
    bx    = sub ? ~b : b;
    cx    = sub ? ~cin : cin;
    sum   = a + bx + {{(DW-1){1'b0}}, cx};
    low   = {1'b0, a[FW-1:0]} + {1'b0, bx[FW-1:0]} + {{FW{1'b0}}, cx};
    c_nar = sub ? ~low[FW] : low[FW];
    v_nar = (a[FW-1] == bx[FW-1]) && (sum[FW-1] != a[FW-1]);
  end
endmodule

// File: rtl/nfa_logic.sv
module nfa_logic #(
  parameter int DW = 24
) (
  input  nfa_pkg::nfa_op_e op,
  input  logic [DW-1:0]    a,
  input  logic [DW-1:0]    b,
  output logic [DW-1:0]    res
);
  import nfa_pkg::*;
  localparam int SHW = $clog2(DW);

  logic [SHW-1:0] amt;
  logic           big;

  always_comb begin
    amt = b[SHW-1:0];
    big = (b[4:0] >= 5'(DW)) || (SHW < 5 && |b[4:SHW]);
    unique case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_NOT:  res = ~a;
      OP_SLL:  res = big ? '0 : (a << amt);
      OP_SRL:  res = big ? '0 : (a >> amt);
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/nfa_status.sv
module nfa_status #(
  parameter int LW = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                flg_en,
  input  nfa_pkg::nfa_flags_t flg_d,
  input  logic                mode_we,
  input  logic [LW:0]         mode_d,
  output logic [LW+4:0]       stat_q
);
  logic [LW:0]         mode_q;
  nfa_pkg::nfa_flags_t flg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      flg_q  <= '0;
    end else begin
      if (mode_we) mode_q <= mode_d;
      if (flg_en)  flg_q  <= flg_d;
    end
  end

  assign stat_q = {mode_q, flg_q};

  a_r12_flags_hold: assert property (@(posedge clk) disable iff (rst)
    !flg_en |=> $stable(stat_q[3:0]));
  a_r13_mode_hold: assert property (@(posedge clk) disable iff (rst)
    !mode_we |=> $stable(stat_q[LW+4:4]));
  a_r13_mode_load: assert property (@(posedge clk) disable iff (rst)
    mode_we |=> stat_q[LW+4:4] == $past(mode_d));
endmodule

// File: rtl/nfa_alu.sv
module nfa_alu #(
  parameter int DW = 24,
  parameter int FW = 16,
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [3:0]    op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          flg_en_i,
  input  logic          mode_we_i,
  input  logic [LW:0]   mode_d_i,
  output logic [DW-1:0] res_o,
  output logic [LW+4:0] stat_o
);
  import nfa_pkg::*;

  nfa_op_e       op;
  logic          is_ar, is_sub, use_c, c_q;
  logic [DW-1:0] ar_sum, lg_res, val;
  logic          ar_c, ar_v;
  nfa_flags_t    flg_d;

  assign op  = nfa_op_e'(op_i);
  assign c_q = stat_o[3];

  always_comb begin
    is_ar  = (op_i <= 4'd4);
    is_sub = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP);
    use_c  = (op == OP_ADC) || (op == OP_SBC);
  end

  nfa_arith #(.DW(DW), .FW(FW)) u_arith (
    .a(a_i), .b(b_i), .sub(is_sub), .cin(use_c & c_q),
    .sum(ar_sum), .c_nar(ar_c), .v_nar(ar_v)
  );

  nfa_logic #(.DW(DW)) u_logic (
    .op(op), .a(a_i), .b(b_i), .res(lg_res)
  );

  always_comb begin
    val     = is_ar ? ar_sum : lg_res;
    res_o   = (op == OP_CMP) ? a_i : val;
    flg_d.c = is_ar ? ar_c : c_q;
    flg_d.v = is_ar ? ar_v : 1'b0;
    flg_d.z = (val[FW-1:0] == '0);
    flg_d.n = val[FW-1];
  end

  nfa_status #(.LW(LW)) u_status (
    .clk(clk), .rst(rst), .flg_en(flg_en_i), .flg_d(flg_d),
    .mode_we(mode_we_i), .mode_d(mode_d_i), .stat_q(stat_o)
  );

  a_r7_logic_clears_v: assert property (@(posedge clk) disable iff (rst)
    (flg_en_i && op_i >= 4'd5 && op_i <= 4'd8) |=> !stat_o[2]);
  a_r8_shift_keeps_c: assert property (@(posedge clk) disable iff (rst)
    (flg_en_i && op_i >= 4'd9) |=> $stable(stat_o[3]));
  a_r9_zero_low_half: assert property (@(posedge clk) disable iff (rst)
    (flg_en_i && op_i != 4'd4) |=> stat_o[1] == ($past(res_o[FW-1:0]) == '0));
  a_r10_neg_bit: assert property (@(posedge clk) disable iff (rst)
    (flg_en_i && op_i != 4'd4) |=> stat_o[0] == $past(res_o[FW-1]));
endmodule

// File: tb/test_nfa_alu.sv
module test_nfa_alu;
  localparam int DW = 24;
  localparam int NV = 21;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [3:0]    op_i = '0;
  logic [DW-1:0] a_i = '0, b_i = '0;
  logic          flg_en_i = 1'b0, mode_we_i = 1'b0;
  logic [3:0]    mode_d_i = '0;
  logic [DW-1:0] res_o;
  logic [7:0]    stat_o;

  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  nfa_alu i_nfa_alu (
    .clk(clk), .rst(rst), .op_i(op_i), .a_i(a_i), .b_i(b_i),
    .flg_en_i(flg_en_i), .mode_we_i(mode_we_i), .mode_d_i(mode_d_i),
    .res_o(res_o), .stat_o(stat_o)
  );

  // {op, A, B, preset C, expected result, expected {C,V,Z,N}}
  localparam logic [80:0] VEC [NV] = '{
    {4'd0,  24'h00FFFF, 24'h000001, 1'b0, 24'h010000, 4'hA},
    {4'd0,  24'h007FFF, 24'h000001, 1'b0, 24'h008000, 4'h5},
    {4'd0,  24'h128000, 24'h008000, 1'b0, 24'h130000, 4'hE},
    {4'd1,  24'h000010, 24'h000020, 1'b1, 24'h000031, 4'h0},
    {4'd1,  24'h000010, 24'h000020, 1'b0, 24'h000030, 4'h0},
    {4'd1,  24'h00FFFF, 24'h000000, 1'b1, 24'h010000, 4'hA},
    {4'd2,  24'h000005, 24'h000007, 1'b0, 24'hFFFFFE, 4'h9},
    {4'd2,  24'h008000, 24'h000001, 1'b0, 24'h007FFF, 4'h4},
    {4'd2,  24'h007FFF, 24'h00FFFF, 1'b0, 24'hFF8000, 4'hD},
    {4'd3,  24'h000005, 24'h000005, 1'b1, 24'hFFFFFF, 4'h9},
    {4'd3,  24'h000005, 24'h000005, 1'b0, 24'h000000, 4'h2},
    {4'd4,  24'h123456, 24'h123456, 1'b0, 24'h123456, 4'h2},
    {4'd4,  24'h000001, 24'h000002, 1'b1, 24'h000001, 4'h9},
    {4'd5,  24'hFF00FF, 24'h0F0F0F, 1'b1, 24'h0F000F, 4'h8},
    {4'd6,  24'h120000, 24'h340000, 1'b0, 24'h360000, 4'h2},
    {4'd7,  24'h00AAAA, 24'h00AAAA, 1'b1, 24'h000000, 4'hA},
    {4'd8,  24'h0F7FFF, 24'h000000, 1'b0, 24'hF08000, 4'h1},
    {4'd9,  24'h000001, 24'h00000F, 1'b1, 24'h008000, 4'h9},
    {4'd9,  24'h000001, 24'h000010, 1'b0, 24'h010000, 4'h2},
    {4'd10, 24'h800000, 24'h000008, 1'b1, 24'h008000, 4'h9},
    {4'd10, 24'h123456, 24'h00001F, 1'b0, 24'h000000, 4'h2}
  };

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] op, input logic [DW-1:0] a, input logic [DW-1:0] b,
                       input logic fen, input logic mwe, input logic [3:0] md);
    @(negedge clk);
    op_i = op; a_i = a; b_i = b; flg_en_i = fen; mode_we_i = mwe; mode_d_i = md;
    #1;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    flg_en_i = 1'b0; mode_we_i = 1'b0;
  endtask

  task automatic preset_c(input logic c);
    drive(4'd0, c ? 24'h00FFFF : 24'h0, c ? 24'h1 : 24'h0, 1'b1, 1'b0, 4'h0);
    step();
  endtask

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'd0, 4'd1: return "R2 R3 R5 R9 R10";
      4'd2, 4'd3: return "R4 R6 R9 R10";
      4'd4:       return "R11";
      4'd9, 4'd10: return "R8";
      default:    return "R7 R9 R10";
    endcase
  endfunction

  initial begin
    #100000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset status", {16'h0, stat_o}, 24'h0);
    drive(4'd0, 24'h0, 24'h0, 1'b0, 1'b0, 4'h0);
    rst = 1'b0;
    step();

    for (int i = 0; i < NV; i++) begin
      logic [3:0] op; logic [DW-1:0] a, b, er; logic c; logic [3:0] ef;
      {op, a, b, c, er, ef} = VEC[i];
      preset_c(c);
      drive(op, a, b, 1'b1, 1'b0, 4'h0);
      chk({tag_of(op), " result"}, res_o, er);
      step();
      chk({tag_of(op), " flags"}, {16'h0, stat_o}, {20'h0, ef});
    end

    // R1 R13: mode bits load into 7..4 without touching flags
    preset_c(1'b0);
    drive(4'd0, 24'h0, 24'h0, 1'b0, 1'b1, 4'hB);
    step();
    chk("R1 R13 mode load", {16'h0, stat_o}, 24'hB2);
    // R13 R5: arithmetic leaves mode bits, sets V
    drive(4'd0, 24'h007FFF, 24'h000001, 1'b1, 1'b0, 4'h4);
    step();
    chk("R13 R5 mode kept", {16'h0, stat_o}, 24'hB5);
    // R7: logical op clears a set V, keeps C
    drive(4'd5, 24'h00FFFF, 24'h008000, 1'b1, 1'b0, 4'h0);
    step();
    chk("R7 V cleared", {16'h0, stat_o}, 24'hB1);
    // R8: shift clears a set V
    drive(4'd0, 24'h007FFF, 24'h000001, 1'b1, 1'b0, 4'h0);
    step();
    drive(4'd10, 24'h010000, 24'h000001, 1'b1, 1'b0, 4'h0);
    chk("R8 shift result", res_o, 24'h008000);
    step();
    chk("R8 V cleared", {16'h0, stat_o}, 24'hB1);
    // R12: flags held with update low, result still live
    drive(4'd2, 24'h0, 24'h1, 1'b0, 1'b0, 4'h0);
    chk("R12 result live", res_o, 24'hFFFFFF);
    step();
    chk("R12 flags held", {16'h0, stat_o}, 24'hB1);
    // R1: reset again clears the whole byte
    rst = 1'b1;
    step();
    chk("R1 reset clears", {16'h0, stat_o}, 24'h0);
    rst = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule